// File: doc/BRIEF.md
# Single-Error-Correct / Double-Error-Detect Word Codec

This block guards a 16-bit word with 6 redundant bits so that it can sit in storage that may flip bits. The encoder path takes a data word and produces a 22-bit protected word: five position-coded check bits laid out Hamming style, plus one overall parity bit at bit 0. The decoder path takes a 22-bit word read back from storage. It returns the 16 data bits, with any single flipped bit repaired, and a 2-bit status code that tells the caller what it found.

The two paths are independent and purely combinational inside. By default each path ends in one register stage, which a parameter can remove. With the register stage present, both outputs follow their inputs by one clock, and a synchronous active-low reset clears them to zero. Storage, scrubbing and retry decisions belong to the surrounding logic.

Top module: `secded_codec`

## Requirements
- R1: Protected word layout. Bit 0 holds the overall parity. Bits 1, 2, 4, 8 and 16 hold check bits C0..C4. Data bits D0..D15 occupy bits 3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20 and 21, lowest data bit at the lowest position.
- R2: Check bit Cj is the XOR of every data bit whose position has bit j set. So C0 = D0^D1^D3^D4^D6^D8^D10^D11^D13^D15, C1 = D0^D2^D3^D5^D6^D9^D10^D12^D13, C2 = D1^D2^D3^D7^D8^D9^D10^D14^D15, C3 = XOR of D4..D10, and C4 = XOR of D11..D15.
- R3: Bit 0 of an encoded word makes the XOR of all 22 bits equal 0.
- R4: A word that decodes clean gives status 00 and returns its data bits unchanged.
- R5: A single flipped bit at a data position gives status 01, and the returned data equals the original data.
- R6: A single flipped check bit (positions 1, 2, 4, 8, 16) gives status 01, and the returned data equals the stored data.
- R7: Two flipped bits anywhere, including bit 0, give status 10, and the returned data is the raw data field of the received word with no correction.
- R8: A flip confined to bit 0 gives status 11, and the returned data is unchanged.
- R9: An odd number of flips whose syndrome names a position above 21 (values 22..31) gives status 10 with the raw data field.
- R10: With registered outputs (the default), each output reflects the inputs sampled at the previous rising clock edge. While rst_n is low at an edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output registers |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_data_i | input | 16 | Data word to protect |
| enc_code_o | output | 22 | Protected word produced from enc_data_i |
| dec_code_i | input | 22 | Protected word read back from storage |
| dec_data_o | output | 16 | Repaired (or raw, when uncorrectable) data |
| dec_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable, 11 parity bit only |

## Verification
The hardest case to reach is a syndrome with bad overall parity that points past the last occupied position. No single or double flip can produce it. The bench builds it by flipping bits 2, 4 and 16 of a valid word, which gives syndrome 22 with odd parity. The second delicate case is a flip that lands on a check bit. The bench walks every power-of-two position and checks that the data comes back untouched while the status still reports a correction. Double flips are driven as every adjacent pair from (0,1) to (20,21), so the pairs that include the overall parity bit are covered too.

// File: rtl/secded_pkg.sv
// Shared helpers for the SECDED codec: code geometry and status encoding.
// Assumes data widths small enough that positions fit in a 32-bit int.
package secded_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'b00,
        ST_FIXED  = 2'b01,
        ST_DOUBLE = 2'b10,
        ST_PARITY = 2'b11
    } dec_status_t;

    // Smallest m with 2^m >= m + k + 1.
    function automatic int chk_bits(input int k);
        int m;
        m = 0;
        while ((1 << m) < (m + k + 1)) m++;
        return m;
    endfunction

    // Full protected width: data + position checks + overall parity.
    function automatic int code_w(input int k);
        return k + chk_bits(k) + 1;
    endfunction

    // True when p is a power of two (a check-bit slot).
    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // Position of data bit i among the non-power-of-two slots, counting from 1.
    function automatic int data_pos(input int i);
        int p;
        int n;
        p = 0;
        n = -1;
        while (n < i) begin
            p++;
            if (!is_pow2(p)) n++;
        end
        return p;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
// Encoder: places data in the non-power-of-two slots, computes one check
// bit per syndrome bit, then an overall parity bit in slot 0.
// Assumes DATA_W >= 1; purely combinational.
module secded_encoder
    import secded_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = code_w(DATA_W),
    localparam int HAM_N  = CODE_W - 1
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [HAM_N:1]   placed;
    logic [CHK_W-1:0] chk;

    // Scatter data bits into their slots; check slots start at zero.
    always_comb begin
        placed = '0;
        for (int i = 0; i < DATA_W; i++) begin
            placed[data_pos(i)] = data_i[i];
        end
    end

    // One check bit per syndrome bit: parity of slots whose index has that bit.
    always_comb begin
        for (int j = 0; j < CHK_W; j++) begin
            chk[j] = 1'b0;
            for (int p = 1; p <= HAM_N; p++) begin
                if (p[j]) chk[j] = chk[j] ^ placed[p];
            end
        end
    end

    // Assemble the word and close it with the overall parity bit.
    always_comb begin
        code_o = '0;
        code_o[HAM_N:1] = placed;
        for (int j = 0; j < CHK_W; j++) begin
            code_o[1 << j] = chk[j];
        end
        code_o[0] = ^code_o[HAM_N:1];
    end

endmodule

// File: rtl/secded_syndrome.sv
// Syndrome generator: received checks XOR recomputed checks, which is the
// parity of every slot whose index has the given bit set. Also reports
// whether the whole word has odd parity. Combinational.
module secded_syndrome
    import secded_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = code_w(DATA_W),
    localparam int HAM_N  = CODE_W - 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CHK_W-1:0]  syn_o,
    output logic              odd_o
);

    // Syndrome bit j folds every slot whose index has bit j set.
    always_comb begin
        for (int j = 0; j < CHK_W; j++) begin
            syn_o[j] = 1'b0;
            for (int p = 1; p <= HAM_N; p++) begin
                if (p[j]) syn_o[j] = syn_o[j] ^ code_i[p];
            end
        end
    end

    // Overall parity across all slots including slot 0.
    always_comb odd_o = ^code_i;

endmodule

// File: rtl/secded_corrector.sv
// Corrector: classifies the error from syndrome and parity, flips the named
// slot for a single error, and gathers the data bits. A syndrome beyond the
// last slot is treated as uncorrectable. Combinational.
module secded_corrector
    import secded_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = code_w(DATA_W),
    localparam int HAM_N  = CODE_W - 1
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [CHK_W-1:0]  syn_i,
    input  logic              odd_i,
    output logic [DATA_W-1:0] data_o,
    output dec_status_t       status_o
);

    localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(HAM_N);

    logic [CODE_W-1:0] fixed;

    // Decide the status from syndrome and parity.
    always_comb begin
        if (syn_i == '0) begin
            status_o = odd_i ? ST_PARITY : ST_CLEAN;
        end else if (!odd_i) begin
            status_o = ST_DOUBLE;
        end else if (syn_i > LAST_POS) begin
            status_o = ST_DOUBLE;
        end else begin
            status_o = ST_FIXED;
        end
    end

    // Flip the slot named by the syndrome only for a correctable single error.
    always_comb begin
        fixed = code_i;
        if (status_o == ST_FIXED) begin
            fixed = code_i ^ (CODE_W'(1) << syn_i);
        end
    end

    // Gather data bits from their slots.
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            data_o[i] = fixed[data_pos(i)];
        end
    end

endmodule

// File: rtl/secded_outreg.sv
// Optional output stage: one clocked register with synchronous active-low
// reset to zero when ENABLE is set, a plain wire otherwise.
module secded_outreg #(
    parameter int W      = 8,
    parameter bit ENABLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (ENABLE) begin : g_reg
            // Capture the stage input each edge; clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q_o <= '0;
                else        q_o <= d_i;
            end
        end else begin : g_wire
            // Pass the stage input straight through.
            always_comb q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/secded_codec.sv
// Top level of the SECDED codec. Encoder and decoder paths are independent;
// each ends in an optional register stage (OUT_REG). Assumes the decoder
// input is a word previously built by a matching encoder.
module secded_codec
    import secded_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int CHK_W  = chk_bits(DATA_W),
    localparam int CODE_W = code_w(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [1:0]        dec_status_o
);

    logic [CODE_W-1:0] enc_code_c;
    logic [CHK_W-1:0]  syn_c;
    logic              odd_c;
    logic [DATA_W-1:0] dec_data_c;
    dec_status_t       dec_status_c;

    secded_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    secded_syndrome #(.DATA_W(DATA_W)) u_syn (
        .code_i (dec_code_i),
        .syn_o  (syn_c),
        .odd_o  (odd_c)
    );

    secded_corrector #(.DATA_W(DATA_W)) u_fix (
        .code_i   (dec_code_i),
        .syn_i    (syn_c),
        .odd_i    (odd_c),
        .data_o   (dec_data_c),
        .status_o (dec_status_c)
    );

    secded_outreg #(.W(CODE_W), .ENABLE(OUT_REG)) u_enc_q (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (enc_code_c),
        .q_o   (enc_code_o)
    );

    secded_outreg #(.W(DATA_W + 2), .ENABLE(OUT_REG)) u_dec_q (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({dec_status_c, dec_data_c}),
        .q_o   ({dec_status_o, dec_data_o})
    );

endmodule

// File: rtl/secded_codec_chk.sv
// Property checker for secded_codec, attached by bind. It keeps its own
// copy of the inputs seen one edge earlier (when outputs are registered)
// and relates them to the outputs.
module secded_codec_chk
    import secded_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit OUT_REG = 1'b1,
    localparam int CODE_W = code_w(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] enc_data_i,
    input logic [CODE_W-1:0] enc_code_o,
    input logic [CODE_W-1:0] dec_code_i,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [1:0]        dec_status_o
);

    logic              armed_q;
    logic [DATA_W-1:0] enc_seen_q;
    logic [CODE_W-1:0] dec_seen_q;
    logic              armed;
    logic [DATA_W-1:0] enc_seen;
    logic [CODE_W-1:0] dec_seen;

    // Pull the data field out of a protected word.
    function automatic logic [DATA_W-1:0] field(input logic [CODE_W-1:0] w);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W; i++) r[i] = w[data_pos(i)];
        return r;
    endfunction

    // Remember last-edge inputs and whether one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            enc_seen_q <= '0;
            dec_seen_q <= '0;
        end else begin
            armed_q    <= 1'b1;
            enc_seen_q <= enc_data_i;
            dec_seen_q <= dec_code_i;
        end
    end

    // Select the input view matching the output timing.
    always_comb begin
        armed    = OUT_REG ? armed_q    : 1'b1;
        enc_seen = OUT_REG ? enc_seen_q : enc_data_i;
        dec_seen = OUT_REG ? dec_seen_q : dec_code_i;
    end

    // R3: encoded words always have even overall parity.
    p_enc_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (^enc_code_o) == 1'b0);

    // R1: the data field of the encoded word carries the data that went in.
    p_enc_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> field(enc_code_o) == enc_seen);

    // R4: a clean status returns the data field as received.
    p_clean_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_status_o == ST_CLEAN) |-> dec_data_o == field(dec_seen));

    // R5: a correction is only reported for a word with odd parity.
    p_fixed_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_status_o == ST_FIXED) |-> (^dec_seen) == 1'b1);

    // R7: uncorrectable words pass their data field through untouched.
    p_double_raw_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_status_o == ST_DOUBLE) |-> dec_data_o == field(dec_seen));

    // R8: a parity-only error keeps data intact and had odd parity.
    p_parity_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dec_status_o == ST_PARITY) |->
            (dec_data_o == field(dec_seen)) && ((^dec_seen) == 1'b1));

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/secded_codec_tb.sv
// Directed bench for secded_codec with default parameters (16-bit data,
// registered outputs). Expected values come from the written-out check
// equations and the slot table in the requirements.
module secded_codec_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] enc_data_i = '0;
    logic [21:0] enc_code_o;
    logic [21:0] dec_code_i = '0;
    logic [15:0] dec_data_o;
    logic [1:0]  dec_status_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam int SLOT [16] = '{3, 5, 6, 7, 9, 10, 11, 12, 13, 14, 15, 17, 18, 19, 20, 21};

    always #4 clk = ~clk;

    secded_codec u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enc_data_i   (enc_data_i),
        .enc_code_o   (enc_code_o),
        .dec_code_i   (dec_code_i),
        .dec_data_o   (dec_data_o),
        .dec_status_o (dec_status_o)
    );

    function automatic logic [21:0] ref_enc(input logic [15:0] d);
        logic [21:0] c;
        c = '0;
        for (int i = 0; i < 16; i++) c[SLOT[i]] = d[i];
        c[1]  = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[11]^d[13]^d[15];
        c[2]  = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[10]^d[12]^d[13];
        c[4]  = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[10]^d[14]^d[15];
        c[8]  = ^d[10:4];
        c[16] = ^d[15:11];
        c[0]  = ^c[21:1];
        return c;
    endfunction

    function automatic logic [15:0] raw(input logic [21:0] c);
        logic [15:0] d;
        for (int i = 0; i < 16; i++) d[i] = c[SLOT[i]];
        return d;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] d, input logic [21:0] c);
        @(negedge clk);
        enc_data_i = d;
        dec_code_i = c;
        @(posedge clk);
        #1;
    endtask

    task automatic decode_expect(input logic [21:0] c, input logic [1:0] st,
                                 input logic [15:0] d, input string req);
        drive(16'h0, c);
        check(dec_status_o == st, {req, " status"}, 32'(dec_status_o), 32'(st));
        check(dec_data_o == d, {req, " data"}, 32'(dec_data_o), 32'(d));
    endtask

    // R10: outputs held at zero while reset is low.
    task automatic t_reset();
        enc_data_i = 16'hBEEF;
        dec_code_i = 22'h3FFFFF;
        repeat (3) @(posedge clk);
        #1;
        check(enc_code_o == '0, "R10 reset enc", 32'(enc_code_o), 0);
        check(dec_data_o == '0, "R10 reset data", 32'(dec_data_o), 0);
        check(dec_status_o == 2'b00, "R10 reset status", 32'(dec_status_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1 R2 R3: encoder against the written equations.
    task automatic t_encode();
        logic [15:0] v [8] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0001,
                               16'h8000, 16'h1234, 16'h5A0F, 16'hC3E7};
        foreach (v[k]) begin
            drive(v[k], '0);
            check(enc_code_o == ref_enc(v[k]), "R1 R2 encode", 32'(enc_code_o), 32'(ref_enc(v[k])));
            check((^enc_code_o) == 1'b0, "R3 parity", 32'(^enc_code_o), 0);
        end
    endtask

    // R4: clean words.
    task automatic t_clean();
        decode_expect(ref_enc(16'h0000), 2'b00, 16'h0000, "R4");
        decode_expect(ref_enc(16'hFFFF), 2'b00, 16'hFFFF, "R4");
        decode_expect(ref_enc(16'h6C91), 2'b00, 16'h6C91, "R4");
    endtask

    // R5: every data slot flipped once.
    task automatic t_single_data();
        logic [15:0] d = 16'hA5C3;
        for (int i = 0; i < 16; i++) begin
            decode_expect(ref_enc(d) ^ (22'h1 << SLOT[i]), 2'b01, d, "R5");
        end
    endtask

    // R6: every check slot flipped once.
    task automatic t_single_check();
        logic [15:0] d = 16'h3C5A;
        for (int j = 0; j < 5; j++) begin
            decode_expect(ref_enc(d) ^ (22'h1 << (1 << j)), 2'b01, d, "R6");
        end
    endtask

    // R7: adjacent pairs, including pairs with slot 0.
    task automatic t_double();
        logic [15:0] d = 16'h0F0F;
        logic [21:0] c;
        for (int i = 0; i < 21; i++) begin
            c = ref_enc(d) ^ (22'h3 << i);
            decode_expect(c, 2'b10, raw(c), "R7");
        end
    endtask

    // R8: flip confined to slot 0.
    task automatic t_parity_only();
        decode_expect(ref_enc(16'h9E21) ^ 22'h1, 2'b11, 16'h9E21, "R8");
        decode_expect(ref_enc(16'h0000) ^ 22'h1, 2'b11, 16'h0000, "R8");
    endtask

    // R9: slots 2, 4 and 16 flipped give syndrome 22 with odd parity.
    task automatic t_beyond();
        logic [21:0] c;
        c = ref_enc(16'h7B3D) ^ 22'h010014;
        decode_expect(c, 2'b10, raw(c), "R9");
    endtask

    // R10: one-edge latency; output holds until the next rising edge.
    task automatic t_latency();
        drive(16'h1111, ref_enc(16'h2222));
        @(negedge clk);
        enc_data_i = 16'h4444;
        dec_code_i = ref_enc(16'h8888);
        #1;
        check(enc_code_o == ref_enc(16'h1111), "R10 hold enc", 32'(enc_code_o), 32'(ref_enc(16'h1111)));
        check(dec_data_o == 16'h2222, "R10 hold dec", 32'(dec_data_o), 32'h2222);
        @(posedge clk);
        #1;
        check(enc_code_o == ref_enc(16'h4444), "R10 update enc", 32'(enc_code_o), 32'(ref_enc(16'h4444)));
        check(dec_data_o == 16'h8888, "R10 update dec", 32'(dec_data_o), 32'h8888);
    endtask

    initial begin
        t_reset();
        t_encode();
        t_clean();
        t_single_data();
        t_single_check();
        t_double();
        t_parity_only();
        t_beyond();
        t_latency();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule